// File: doc/BRIEF.md
# Status Field Command Engine

This block interprets the byte commands a host sends to a small one-time-programmable status area of eight bytes once the device has been selected. Bit-slot timing is handled elsewhere. The engine sees whole received bytes (`rx_valid`/`rx_data`) and read requests (`tx_req`), and each read request gets exactly one reply byte (`tx_valid`/`tx_data`). A one-cycle `bus_rst` input stands for the line reset pulse. A `prog_strobe` input stands for the programming voltage pulse.

A read command echoes a CRC over the command and the address. It then streams the status bytes from the start address to the end of the area, followed by a CRC over only the streamed bytes. After that it returns all-ones. A write command takes an address and a data byte and echoes a CRC over all four bytes. It then waits for a confirm byte and the program strobe. Programming can only clear bits.

Top module: `status_cmd_engine`

## Requirements
- R1: While `rst_n` is low, `tx_valid` is held low, status bytes 0 to 6 return to FFh and byte 7 reads 00h. Byte 7 reads 00h at all times.
- R2: Each cycle with `tx_req` high produces `tx_valid` high in exactly the next cycle. `tx_valid` is never high at any other time.
- R3: Command AAh, then the address low byte, then the address high byte starts a read. The first reply is a CRC over those three bytes. The CRC is reflected x^8+x^5+x^4+1: for each bit, LSB first, shift right and XOR 8Ch when the bit shifted out XOR the input bit is 1. Each CRC segment starts from 00h.
- R4: After the command CRC, replies give the status bytes from the start address up to byte 7. These are followed by one CRC, started fresh from 00h, over exactly those data bytes.
- R5: Once a sequence has ended (data CRC sent, or a program done), every reply is FFh until a bus reset.
- R6: Command 55h, then address low, address high and one data byte, starts a write. The next reply is the CRC over those four bytes.
- R7: A status byte changes only when the byte 5Ah follows the write CRC and `prog_strobe` is then high. The byte becomes old AND data, so a bit can never go from 0 to 1.
- R8: A confirm byte other than 5Ah, or a start address above 7 (including any non-zero high byte), makes every reply FFh until a bus reset. No programming takes place.
- R9: A first byte other than AAh or 55h makes every reply FFh until a bus reset, whatever bytes follow.
- R10: A `bus_rst` pulse returns the engine to idle from any point of any sequence. The next command is then decoded normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also erases the status field |
| bus_rst | input | 1 | Line reset pulse, aborts any sequence |
| rx_valid | input | 1 | A byte from the host is present |
| rx_data | input | 8 | Byte from the host |
| tx_req | input | 1 | Host asks for one byte |
| tx_valid | output | 1 | Reply byte valid, one cycle after `tx_req` |
| tx_data | output | 8 | Reply byte |
| prog_strobe | input | 1 | Programming pulse |

## Verification
Some rules hold on every cycle and the assertions check them there. These are the one-cycle reply timing, all-ones replies in the finished and ignore states, the return to idle after a bus reset, and a status image that stays frozen except on a program enable, where bits can only clear. The bench's scenarios are the only way to show the other behaviour. This covers the CRC values, the order and range of the streamed bytes, the programmed AND result read back through a later read, and the refusal of bad confirms, out-of-range addresses and unknown commands.

// File: rtl/status_pkg.sv
// Package for the status field command engine: command codes, CRC
// polynomial and the sequencer state type. Assumes byte-wide host traffic.
package status_pkg;

    localparam logic [7:0] CMD_READ    = 8'hAA;
    localparam logic [7:0] CMD_WRITE   = 8'h55;
    localparam logic [7:0] CMD_CONFIRM = 8'h5A;
    localparam logic [7:0] CRC_POLY    = 8'h8C;
    localparam logic [7:0] IDLE_BYTE   = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_LO,
        ST_ADDR_HI,
        ST_WDATA,
        ST_CMD_CRC,
        ST_RDATA,
        ST_DATA_CRC,
        ST_CONFIRM,
        ST_ARMED,
        ST_DONE,
        ST_IGNORE
    } seq_state_t;

endpackage

// File: rtl/status_crc8.sv
// Combinational CRC-8 byte step, reflected form, LSB first.
// Assumes the caller holds the running value and picks the seed.
module status_crc8 #(
    parameter logic [7:0] POLY = 8'h8C
) (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);

    // Fold the eight data bits into the running CRC one at a time.
    always_comb begin
        logic [7:0] acc;
        logic       mix;
        acc = crc_in;
        for (int i = 0; i < 8; i++) begin
            mix = acc[0] ^ data_in[i];
            acc = acc >> 1;
            if (mix) acc = acc ^ POLY;
        end
        crc_out = acc;
    end

endmodule

// File: rtl/status_store.sv
// Status field storage: NUM_BYTES-1 programmable bytes that erase to FFh
// on reset and one fixed last byte. Programming ANDs a mask into one byte.
// Assumes prog_idx is in range whenever prog_en is high.
module status_store #(
    parameter int          NUM_BYTES  = 8,
    parameter logic [7:0]  LAST_VALUE = 8'h00,
    localparam int         PTR_W      = $clog2(NUM_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_en,
    input  logic [PTR_W-1:0]         prog_idx,
    input  logic [7:0]               prog_mask,
    output logic [NUM_BYTES*8-1:0]   image
);

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        if (g < NUM_BYTES - 1) begin : g_prog
            logic [7:0] cell_q;
            // Erase on reset; clear masked bits on a program pulse.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= 8'hFF;
                else if (prog_en && (prog_idx == PTR_W'(g)))
                    cell_q <= cell_q & prog_mask;
            end
            assign image[g*8 +: 8] = cell_q;
        end else begin : g_fixed
            assign image[g*8 +: 8] = LAST_VALUE;
        end
    end

endmodule

// File: rtl/status_cmd_engine.sv
// Top of the status field command engine. Decodes read and write commands
// from received bytes, answers each tx_req with one byte a cycle later,
// keeps CRC segments and drives the one-time-programmable store.
// Assumes bus_rst and prog_strobe are single-cycle pulses.
module status_cmd_engine #(
    parameter int NUM_BYTES = 8,
    localparam int PTR_W    = $clog2(NUM_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_req,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       prog_strobe
);
    import status_pkg::*;

    seq_state_t             state_q;
    logic                   is_write_q;
    logic [7:0]             addr_lo_q;
    logic [PTR_W-1:0]       ptr_q;
    logic [7:0]             wdata_q;
    logic [7:0]             crc_q;
    logic [7:0]             crc_seed;
    logic [7:0]             crc_operand;
    logic [7:0]             crc_next;
    logic [7:0]             rd_byte;
    logic [7:0]             reply;
    logic                   prog_en;
    logic                   addr_ok;
    logic [NUM_BYTES*8-1:0] image;

    status_store #(
        .NUM_BYTES  (NUM_BYTES),
        .LAST_VALUE (8'h00)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_idx  (ptr_q),
        .prog_mask (wdata_q),
        .image     (image)
    );

    status_crc8 #(
        .POLY (CRC_POLY)
    ) i_crc (
        .crc_in  (crc_seed),
        .data_in (crc_operand),
        .crc_out (crc_next)
    );

    // Byte at the read pointer.
    assign rd_byte = image[{ptr_q, 3'b000} +: 8];

    // CRC inputs: data bytes while streaming, host bytes otherwise.
    assign crc_operand = (state_q == ST_RDATA) ? rd_byte : rx_data;
    assign crc_seed    = (state_q == ST_IDLE)  ? 8'h00   : crc_q;

    // Full 16-bit start address must land inside the field.
    assign addr_ok = (rx_data == 8'h00) && ({8'h00, addr_lo_q} < 16'(NUM_BYTES));

    // Program only when armed and strobed, never on a bus reset cycle.
    assign prog_en = (state_q == ST_ARMED) && prog_strobe && !bus_rst;

    // Reply byte chosen by the current state.
    always_comb begin
        unique case (state_q)
            ST_CMD_CRC, ST_DATA_CRC: reply = crc_q;
            ST_RDATA:                reply = rd_byte;
            default:                 reply = IDLE_BYTE;
        endcase
    end

    // Reply register: one byte per request, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= IDLE_BYTE;
        end else begin
            tx_valid <= tx_req;
            if (tx_req) tx_data <= reply;
        end
    end

    // Command sequencer with CRC, address and pointer bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst) begin
            state_q    <= ST_IDLE;
            is_write_q <= 1'b0;
            addr_lo_q  <= 8'h00;
            ptr_q      <= '0;
            wdata_q    <= 8'hFF;
            crc_q      <= 8'h00;
        end else begin
            unique case (state_q)
                ST_IDLE: if (rx_valid) begin
                    crc_q <= crc_next;
                    if (rx_data == CMD_READ) begin
                        is_write_q <= 1'b0;
                        state_q    <= ST_ADDR_LO;
                    end else if (rx_data == CMD_WRITE) begin
                        is_write_q <= 1'b1;
                        state_q    <= ST_ADDR_LO;
                    end else begin
                        state_q    <= ST_IGNORE;
                    end
                end
                ST_ADDR_LO: if (rx_valid) begin
                    crc_q     <= crc_next;
                    addr_lo_q <= rx_data;
                    state_q   <= ST_ADDR_HI;
                end
                ST_ADDR_HI: if (rx_valid) begin
                    crc_q <= crc_next;
                    ptr_q <= addr_lo_q[PTR_W-1:0];
                    if (!addr_ok)
                        state_q <= ST_IGNORE;
                    else if (is_write_q)
                        state_q <= ST_WDATA;
                    else
                        state_q <= ST_CMD_CRC;
                end
                ST_WDATA: if (rx_valid) begin
                    crc_q   <= crc_next;
                    wdata_q <= rx_data;
                    state_q <= ST_CMD_CRC;
                end
                ST_CMD_CRC: if (tx_req) begin
                    crc_q   <= 8'h00;
                    state_q <= is_write_q ? ST_CONFIRM : ST_RDATA;
                end
                ST_RDATA: if (tx_req) begin
                    crc_q <= crc_next;
                    if (ptr_q == PTR_W'(NUM_BYTES - 1))
                        state_q <= ST_DATA_CRC;
                    else
                        ptr_q <= ptr_q + 1'b1;
                end
                ST_DATA_CRC: if (tx_req) begin
                    state_q <= ST_DONE;
                end
                ST_CONFIRM: if (rx_valid) begin
                    state_q <= (rx_data == CMD_CONFIRM) ? ST_ARMED : ST_IGNORE;
                end
                ST_ARMED: if (prog_strobe) begin
                    state_q <= ST_DONE;
                end
                default: begin
                    state_q <= state_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/status_engine_chk.sv
// Checker for the status field command engine, bound to the top module.
// Watches reply timing, terminal-state replies, abort and store stability.
module status_engine_chk #(
    parameter int NUM_BYTES = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_rst,
    input logic                     tx_req,
    input logic                     tx_valid,
    input logic [7:0]               tx_data,
    input logic                     prog_en,
    input logic [NUM_BYTES*8-1:0]   image,
    input status_pkg::seq_state_t   state_q
);
    import status_pkg::*;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) $rose(rst_n) |-> !tx_valid);

    // R2
    reply_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> tx_valid);

    // R2
    no_spurious_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> !tx_valid);

    // R5
    done_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE) && tx_req |=> tx_data == 8'hFF);

    // R9
    ignore_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) && tx_req |=> tx_data == 8'hFF);

    // R10
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> state_q == ST_IDLE);

    // R7
    store_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> $stable(image));

    // R7
    only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> (image & ~$past(image)) == '0);

endmodule

bind status_cmd_engine status_engine_chk #(.NUM_BYTES(NUM_BYTES)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_rst  (bus_rst),
    .tx_req   (tx_req),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .prog_en  (prog_en),
    .image    (image),
    .state_q  (state_q)
);

// File: tb/test_status_cmd_engine.sv
// Scoreboard bench: driver tasks queue expected reply bytes, a monitor
// compares each reply as it appears.
module test_status_cmd_engine;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       prog_strobe = 1'b0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    status_cmd_engine i_status_cmd_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rst     (bus_rst),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .tx_req      (tx_req),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .prog_strobe (prog_strobe)
    );

    function automatic logic [7:0] crc_step(logic [7:0] c, logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            logic m;
            m = c[0] ^ b[i];
            c = c >> 1;
            if (m) c = c ^ 8'h8C;
        end
        return c;
    endfunction

    // Monitor: compare each reply with the head of the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && tx_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected reply: actual=%02h expected=none", tx_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (tx_data !== e) begin
                    bad++;
                    $display("FAIL %s reply: actual=%02h expected=%02h", t, tx_data, e);
                end
            end
        end
    end

    task automatic send_byte(logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic read_exp(logic [7:0] e, string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_bus_rst();
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
    endtask

    // Full read from addr: command CRC, data, data CRC, trailing ones.
    task automatic do_read(logic [15:0] addr);
        logic [7:0] c;
        send_byte(8'hAA); send_byte(addr[7:0]); send_byte(addr[15:8]);
        if (addr > 16'd7) begin
            read_exp(8'hFF, "R8");
            read_exp(8'hFF, "R8");
        end else begin
            c = crc_step(crc_step(crc_step(8'h00, 8'hAA), addr[7:0]), addr[15:8]);
            read_exp(c, "R3");
            c = 8'h00;
            for (int a = int'(addr); a < 8; a++) begin
                read_exp(model[a], "R4");
                c = crc_step(c, model[a]);
            end
            read_exp(c, "R4");
            read_exp(8'hFF, "R5");
            read_exp(8'hFF, "R5");
        end
        pulse_bus_rst();
    endtask

    // Write sequence with chosen confirm byte and strobe.
    task automatic do_write(logic [15:0] addr, logic [7:0] d, logic [7:0] conf);
        logic [7:0] c;
        send_byte(8'h55); send_byte(addr[7:0]); send_byte(addr[15:8]);
        if (addr > 16'd7) begin
            read_exp(8'hFF, "R8");
        end else begin
            send_byte(d);
            c = crc_step(crc_step(crc_step(crc_step(8'h00, 8'h55), addr[7:0]), addr[15:8]), d);
            read_exp(c, "R6");
            send_byte(conf);
        end
        @(negedge clk); prog_strobe = 1'b1;
        @(negedge clk); prog_strobe = 1'b0;
        if (addr <= 16'd7 && conf == 8'h5A) begin
            model[addr[2:0]] = model[addr[2:0]] & d;
            read_exp(8'hFF, "R5");
        end else begin
            read_exp(8'hFF, "R8");
        end
        pulse_bus_rst();
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 7; i++) model[i] = 8'hFF;
        model[7] = 8'h00;
        repeat (3) @(negedge clk);
        total++;
        if (tx_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 tx_valid in reset: actual=%b expected=0", tx_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R3 / R4 / R5: erased field read from the start.
        do_read(16'd0);
        // R6 / R7: program, then AND again.
        do_write(16'd2, 8'hA5, 8'h5A);
        do_read(16'd2);
        do_write(16'd2, 8'h0F, 8'h5A);
        do_read(16'd1);
        // R7: fixed last byte stays 00h.
        do_write(16'd7, 8'hFF, 8'h5A);
        do_read(16'd7);
        // R8: bad confirm, out-of-range addresses.
        do_write(16'd4, 8'h00, 8'h33);
        do_write(16'd9, 8'h00, 8'h5A);
        do_write(16'h0104, 8'h00, 8'h5A);
        do_read(16'h0100);
        do_read(16'd8);
        do_read(16'd3);
        // R9: unknown command swallows later traffic.
        send_byte(8'h33);
        read_exp(8'hFF, "R9");
        send_byte(8'hAA); send_byte(8'h00); send_byte(8'h00);
        read_exp(8'hFF, "R9");
        pulse_bus_rst();
        // R10: abort during address and during data.
        send_byte(8'hAA); send_byte(8'h00);
        pulse_bus_rst();
        do_read(16'd5);
        send_byte(8'hAA); send_byte(8'h03); send_byte(8'h00);
        read_exp(crc_step(crc_step(crc_step(8'h00, 8'hAA), 8'h03), 8'h00), "R10");
        read_exp(model[3], "R10");
        pulse_bus_rst();
        do_read(16'd6);

        repeat (4) @(negedge clk);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R2 missing replies: actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule